// File: doc/BRIEF.md
# Prime-Field Binary Euclidean Inverter

This block returns the multiplicative inverse of a nonzero field element modulo an odd prime. Both the element and the modulus are sampled on a start strobe. The block then iterates a binary extended Euclidean procedure that needs nothing wider than shifts, additions, subtractions and one magnitude comparison, and it performs exactly one step per clock. Two working values shrink toward the gcd. Each has a companion coefficient, and every coefficient is kept reduced into the range 0 to p-1 after every step. Halving a coefficient modulo p adds p first whenever the coefficient is odd.

When the first working value reaches zero, the block raises a one-cycle done pulse. The inverse then sits on the output and stays there until the next accepted start. A zero element is rejected at the start: the block raises an error flag together with done in the next cycle and never enters the loop. Start strobes that arrive while a computation is running are ignored. The datapath width is a parameter.

Top module: `pf_bin_inverter`

## Requirements
- R1: After a synchronous active-low reset, done_o and err_o are 0 and inv_o is 0.
- R2: For an odd prime mod_i below 2^W and any elem_i in [1, mod_i-1], the inv_o value shown while done_o is high lies in [0, mod_i-1] and satisfies elem_i * inv_o mod mod_i = 1, with err_o = 0.
- R3: done_o is high for exactly one cycle per accepted start.
- R4: A start with elem_i = 0 raises done_o and err_o together in the cycle right after the start edge, with inv_o = 0. err_o is never high without done_o.
- R5: A start_i pulse that arrives while a computation is in progress has no effect. The running computation finishes with the inverse of the operands accepted first.
- R6: While idle, inv_o holds its last value until the next accepted start.
- R7: The companion coefficients stay within [0, p-1] and the second working value stays nonzero for the whole loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe; accepted only while idle |
| elem_i | input | W | Element to invert, below the modulus |
| mod_i | input | W | Odd prime modulus |
| inv_o | output | W | Inverse result, valid while done_o is high |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero-element error, high together with done_o |

## Verification
The in-line assertions check a set of properties on every cycle. The coefficient registers stay below the modulus while the loop runs, and the second working value never collapses to zero. done_o falls after a single cycle, err_o never appears without done_o, and inv_o does not move while the block is idle. Whether the value delivered is actually the inverse can only be shown by the bench. It compares every result against a brute-force inverse for several primes, including an exhaustive sweep over one 8-bit prime. The bench scenarios also cover the zero-element rejection and the start strobe that must be ignored while the loop is busy.

// File: rtl/pf_inv_pkg.sv
// Package: shared types for the prime-field inverter.
// Assumes nothing beyond the standard enum support.
package pf_inv_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_LOOP = 1'b1
    } inv_state_e;
endpackage

// File: rtl/pf_inv_halver.sv
// Halves an even working value and halves its companion coefficient modulo p.
// Assumes coef_i < p_i and p_i odd, so (coef + p) / 2 stays below p.
module pf_inv_halver #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] coef_i,
    input  logic [W-1:0] p_i,
    output logic [W-1:0] val_o,
    output logic [W-1:0] coef_o
);
    localparam int WX = W + 1;

    logic [WX-1:0] coef_sum;

    // Adds p to an odd coefficient so that the sum is even, then shifts both values.
    always_comb begin
        coef_sum = {1'b0, coef_i} + (coef_i[0] ? {1'b0, p_i} : '0);
        val_o    = val_i >> 1;
        coef_o   = coef_sum[WX-1:1];
    end
endmodule

// File: rtl/pf_inv_modsub.sv
// Computes (a - b) mod p for a, b in [0, p-1].
// Assumes both operands are already reduced; the result is then reduced too.
module pf_inv_modsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] p_i,
    output logic [W-1:0] diff_o
);
    localparam int WX = W + 1;

    logic [WX-1:0] raw;

    // Takes the raw difference and folds a negative one back by adding p.
    always_comb begin
        raw    = {1'b0, a_i} - {1'b0, b_i};
        diff_o = raw[WX-1] ? (raw[W-1:0] + p_i) : raw[W-1:0];
    end
endmodule

// File: rtl/pf_bin_inverter.sv
// Top: multiplicative inverse modulo an odd prime through a binary extended
// Euclidean loop, one step per clock. Assumes elem_i < mod_i and mod_i is an odd
// prime below 2^W. A zero element is flagged and never enters the loop.
module pf_bin_inverter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] elem_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] inv_o,
    output logic         done_o,
    output logic         err_o
);
    import pf_inv_pkg::*;

    inv_state_e   state_q;
    logic [W-1:0] y_q, d_q, b_q, x_q, p_q;
    logic [W-1:0] y_n, d_n, b_n, x_n;
    logic         done_q, err_q;

    logic [W-1:0] y_half, b_half, d_half, x_half;
    logic [W-1:0] b_minus_x, x_minus_b;

    pf_inv_halver #(.W(W)) u_half_y (
        .val_i(y_q), .coef_i(b_q), .p_i(p_q), .val_o(y_half), .coef_o(b_half)
    );
    pf_inv_halver #(.W(W)) u_half_d (
        .val_i(d_q), .coef_i(x_q), .p_i(p_q), .val_o(d_half), .coef_o(x_half)
    );
    pf_inv_modsub #(.W(W)) u_sub_b (
        .a_i(b_q), .b_i(x_q), .p_i(p_q), .diff_o(b_minus_x)
    );
    pf_inv_modsub #(.W(W)) u_sub_x (
        .a_i(x_q), .b_i(b_q), .p_i(p_q), .diff_o(x_minus_b)
    );

    // Picks one loop step: halve Y, else halve D, else compare and subtract.
    always_comb begin
        y_n = y_q;
        d_n = d_q;
        b_n = b_q;
        x_n = x_q;
        if (!y_q[0]) begin
            y_n = y_half;
            b_n = b_half;
        end else if (!d_q[0]) begin
            d_n = d_half;
            x_n = x_half;
        end else if (y_q >= d_q) begin
            y_n = y_q - d_q;
            b_n = b_minus_x;
        end else begin
            d_n = d_q - y_q;
            x_n = x_minus_b;
        end
    end

    // Sequences load, loop and completion and holds the result while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            y_q     <= '0;
            d_q     <= '0;
            b_q     <= '0;
            x_q     <= '0;
            p_q     <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        p_q <= mod_i;
                        x_q <= '0;
                        if (elem_i == '0) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            y_q     <= elem_i;
                            d_q     <= mod_i;
                            b_q     <= W'(1);
                            state_q <= ST_LOOP;
                        end
                    end
                end
                ST_LOOP: begin
                    if (y_q == '0) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        y_q <= y_n;
                        d_q <= d_n;
                        b_q <= b_n;
                        x_q <= x_n;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign inv_o  = x_q;
    assign done_o = done_q;
    assign err_o  = err_q;

    // R7: the coefficients stay reduced and D never collapses during the loop.
    p_coef_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP) |-> (b_q < p_q && x_q < p_q && d_q != '0));

    // R2: a successful result is reduced below the modulus.
    p_inv_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (inv_o < p_q));

    // R3: done is a single-cycle pulse.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: an error is only reported together with done.
    p_err_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R6: the result does not move while idle and not started.
    p_inv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> $stable(inv_o));
endmodule

// File: tb/tb_pf_bin_inverter.sv
module tb_pf_bin_inverter;
    localparam int W = 8;

    typedef struct {
        int a;
        int p;
        int exp_inv;
        bit exp_err;
        string tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] elem_i = '0;
    logic [W-1:0] mod_i = '0;
    logic [W-1:0] inv_o;
    logic         done_o;
    logic         err_o;

    int   n_checks = 0;
    int   n_fail = 0;
    item_t sb_q[$];
    int   last_inv = 0;
    bit   finished = 1'b0;

    pf_bin_inverter #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .elem_i(elem_i),
        .mod_i(mod_i), .inv_o(inv_o), .done_o(done_o), .err_o(err_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int brute_inv(input int a, input int p);
        for (int x = 1; x < p; x++)
            if ((a * x) % p == 1) return x;
        return 0;
    endfunction

    // Driver: waits until the scoreboard is drained, pushes the expectation, pulses start.
    task automatic drive(input int a, input int p, input string tag);
        item_t it;
        wait (sb_q.size() == 0);
        @(negedge clk);
        it.a = a;
        it.p = p;
        it.exp_err = (a == 0);
        it.exp_inv = (a == 0) ? 0 : brute_inv(a, p);
        it.tag = tag;
        sb_q.push_back(it);
        elem_i  = W'(a);
        mod_i   = W'(p);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Monitor: pops an expectation on each done pulse and compares.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3 unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(err_o == it.exp_err, {"R4 err flag ", it.tag}, int'(err_o), int'(it.exp_err));
                if (it.exp_err)
                    check(inv_o == 0, "R4 inv on zero input", int'(inv_o), 0);
                else begin
                    check(int'(inv_o) == it.exp_inv, {"R2 inverse ", it.tag}, int'(inv_o), it.exp_inv);
                    check((it.a * int'(inv_o)) % it.p == 1, "R2 product is one",
                          (it.a * int'(inv_o)) % it.p, 1);
                end
                last_inv = int'(inv_o);
            end
            @(negedge clk);
            check(done_o == 1'b0, "R3 done single cycle", int'(done_o), 0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        check(err_o == 1'b0, "R1 err after reset", int'(err_o), 0);
        check(inv_o == 0, "R1 inv after reset", int'(inv_o), 0);

        // R2: small primes, including the trivial element 1 and p-1
        drive(1, 13, "a1p13");
        drive(12, 13, "a12p13");
        drive(2, 3, "a2p3");
        drive(6, 7, "a6p7");
        drive(100, 127, "a100p127");

        // R4: zero element, done and err in the next cycle
        wait (sb_q.size() == 0);
        @(negedge clk);
        sb_q.push_back('{0, 13, 0, 1'b1, "zero"});
        elem_i = '0; mod_i = W'(13); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b1, "R4 done one cycle after start", int'(done_o), 1);
        wait (sb_q.size() == 0);

        // R5: a second start during the loop is ignored
        drive(7, 13, "a7p13 busy");
        elem_i = W'(5); mod_i = W'(11); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait (sb_q.size() == 0);
        repeat (4) @(negedge clk);
        check(done_o == 1'b0, "R5 no extra done from ignored start", int'(done_o), 0);

        // R6: the result holds while idle
        check(int'(inv_o) == last_inv, "R6 inv held", int'(inv_o), last_inv);
        repeat (10) @(negedge clk);
        check(int'(inv_o) == last_inv, "R6 inv held later", int'(inv_o), last_inv);

        // R2, R7: exhaustive sweep over the largest 8-bit prime
        for (int a = 1; a < 251; a++) drive(a, 251, "p251 sweep");
        wait (sb_q.size() == 0);
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule